// File: doc/BRIEF.md
# Shader Program Sequencer with Return Stack

This block holds the instruction store of a small vector shader and walks through it. Software fills the store through a small write port. One select code rewinds an internal write pointer to word zero. Eight other select codes all act as one data register: each write to any of them puts the word at the pointer and moves the pointer on by one. A further select code holds the 16-bit entry offset where execution begins.

A one-cycle start pulse loads the program counter from the entry offset and clears the return stack. In each running cycle the block presents the word at the program counter, with a valid strobe, to an execution stage outside the block. It then picks the next address. Subroutine-call and return words are handled here against an eight-entry hardware return stack. A return met while the stack is empty ends the program with a one-cycle done pulse. Calling with a full stack sets a sticky error and stops the sequencer until reset.

Top module: `shseq_top`

## Requirements
- R1: A configuration write with select 1 (rewind) sets the program write pointer to word 0.
- R2: A configuration write with any select from 8 to 15 stores the data word at the write pointer, and the pointer then advances by one. All eight selects act the same way.
- R3: A configuration write with select 0 stores the low 16 bits of the data as the entry offset. A start pulse in the idle state makes execution begin at that offset, taken modulo the store depth.
- R4: The opcode is instruction bits 31:26. Every word whose opcode is neither call (0x24) nor return (0x21) is shown with the valid strobe and is followed by the next address. This includes flush (0x22) and unknown codes such as 0x3F.
- R5: A call word (opcode 0x24) saves its own address on the return stack. The next address is the word offset held in bits 21:10.
- R6: A return word (opcode 0x21) with a non-empty stack pops the saved address. Execution continues at the word after the matching call.
- R7: A return word with an empty stack ends the run. Busy drops, and done is high for exactly one cycle, in that same cycle.
- R8: The return stack holds 8 addresses. A call made while it is full raises the sticky overflow error and stops execution without a done pulse. Later start pulses are ignored until reset.
- R9: While the program runs, configuration writes have no effect on the store, the write pointer or the entry offset.
- R10: After reset, busy, done, overflow error and the valid strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Select: 0 entry offset, 1 rewind pointer, 8-15 program data |
| cfg_data | input | 32 | Configuration write data |
| start | input | 1 | One-cycle start pulse |
| busy | output | 1 | High while the program runs |
| done | output | 1 | One-cycle pulse when the top-level program returns |
| ovf_err | output | 1 | Sticky return-stack overflow error |
| instr_valid | output | 1 | Instruction word below is valid this cycle |
| instr_pc | output | 10 | Address of the presented instruction |
| instr_word | output | 32 | Presented instruction word |

## Verification
The embedded assertions check these rules on every cycle:
- done is a single-cycle pulse that never coincides with busy.
- The overflow flag never clears and never coincides with busy.
- A start pulse in the idle state leads to execution at the entry offset.
- The write pointer rewinds or steps exactly as commanded.
- The stack is never pushed when full or popped when empty, and it never returns its invalid marker.

The address order of a run can only be shown by the bench's directed programs. These include nested calls down to full depth, return to the word after each call, unknown and flush opcodes, and an overflow on the ninth nested call. The same goes for the requirements that writes made during a run, and a start after an overflow, leave no trace.

// File: rtl/shseq_pkg.sv
// Package: shared encodings for the shader program sequencer.
// Assumes 32-bit instruction words with the opcode in the top six bits.
package shseq_pkg;

    localparam int WORD_W = 32;

    localparam logic [5:0] OP_CALL = 6'h24;
    localparam logic [5:0] OP_RET  = 6'h21;
    localparam logic [5:0] OP_FLS  = 6'h22;

    localparam logic [3:0] SEL_ENTRY  = 4'd0;
    localparam logic [3:0] SEL_REWIND = 4'd1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/shseq_imem.sv
// Module: instruction store with one write port and one asynchronous read port.
// Assumes the writer never targets an address outside DEPTH.
module shseq_imem #(
    parameter int DEPTH = 1024,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Store a word when the loader requests it.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/shseq_loader.sv
// Module: configuration decode. Keeps the entry offset and the auto-incrementing
// program write pointer. Assumes lock is high for the whole of a run.
module shseq_loader
    import shseq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              lock,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [15:0]       entry_ofs
);

    logic [AW-1:0] wptr;
    logic          accept;
    logic          is_data;

    assign accept  = cfg_wr && !lock;
    assign is_data = cfg_sel[3];

    assign mem_we    = accept && is_data;
    assign mem_waddr = wptr;
    assign mem_wdata = cfg_data;

    // Update the entry offset and the write pointer on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            entry_ofs <= '0;
        end else if (accept) begin
            if (is_data) begin
                wptr <= wptr + AW'(1);
            end else if (cfg_sel == SEL_REWIND) begin
                wptr <= '0;
            end else if (cfg_sel == SEL_ENTRY) begin
                entry_ofs <= cfg_data[15:0];
            end
        end
    end

    // R1
    rewind_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !lock && cfg_sel == SEL_REWIND) |=> (wptr == '0));

    // R2
    step_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !lock && cfg_sel[3]) |=> (wptr == $past(wptr) + AW'(1)));

    // R9
    locked_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock)) |-> ($stable(wptr) && $stable(entry_ofs)));

endmodule

// File: rtl/shseq_rstack.sv
// Module: return-address stack. Clear fills every entry with the all-ones
// invalid marker. Assumes push is never asked when full and pop never when empty.
module shseq_rstack #(
    parameter int SDEPTH = 8,
    parameter int AW     = 10,
    localparam int CW    = $clog2(SDEPTH + 1),
    localparam int IW    = (SDEPTH > 1) ? $clog2(SDEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr,
    output logic          empty,
    output logic          full
);

    logic [AW-1:0] ent [SDEPTH];
    logic [CW-1:0] cnt;
    logic [IW-1:0] top_idx;
    logic [IW-1:0] free_idx;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(SDEPTH));
    assign top_idx  = IW'(cnt - CW'(1));
    assign free_idx = IW'(cnt);
    assign top_addr = empty ? '1 : ent[top_idx];

    // Track the fill count and the entries; popped slots return to the marker.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            for (int i = 0; i < SDEPTH; i++) begin
                ent[i] <= '1;
            end
        end else if (push) begin
            ent[free_idx] <= push_addr;
            cnt           <= cnt + CW'(1);
        end else if (pop) begin
            ent[top_idx] <= '1;
            cnt          <= cnt - CW'(1);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R6
    valid_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (top_addr != '1));

endmodule

// File: rtl/shseq_top.sv
// Module: shader program sequencer. Owns the instruction store, the program
// counter and the return stack. It presents each fetched word to an external
// execution stage and handles call and return itself. Assumes start is a
// single-cycle pulse.
module shseq_top
    import shseq_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int SDEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              ovf_err,
    output logic              instr_valid,
    output logic [AW-1:0]     instr_pc,
    output logic [WORD_W-1:0] instr_word
);

    seq_state_t        state;
    logic [AW-1:0]     pc;
    logic [WORD_W-1:0] rdata;
    logic [5:0]        opcode;
    logic              is_call;
    logic              is_ret;
    logic              running;

    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    logic [15:0]       entry_ofs;

    logic              stk_clear;
    logic              stk_push;
    logic              stk_pop;
    logic [AW-1:0]     stk_top;
    logic              stk_empty;
    logic              stk_full;

    shseq_loader #(.DEPTH(DEPTH)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .lock      (running),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .entry_ofs (entry_ofs)
    );

    shseq_imem #(.DEPTH(DEPTH), .W(WORD_W)) u_imem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (pc),
        .rdata (rdata)
    );

    shseq_rstack #(.SDEPTH(SDEPTH), .AW(AW)) u_rstack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (stk_clear),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_addr (pc),
        .top_addr  (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    assign running = (state == ST_RUN);
    assign opcode  = rdata[WORD_W-1 -: 6];
    assign is_call = (opcode == OP_CALL);
    assign is_ret  = (opcode == OP_RET);

    // Decide the stack operations for this cycle.
    always_comb begin
        stk_clear = (state == ST_IDLE) && start;
        stk_push  = running && is_call && !stk_full;
        stk_pop   = running && is_ret && !stk_empty;
    end

    // Sequencer state, program counter, done pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pc      <= '0;
            done    <= 1'b0;
            ovf_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc    <= entry_ofs[AW-1:0];
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (is_call) begin
                        if (stk_full) begin
                            ovf_err <= 1'b1;
                            state   <= ST_HALT;
                        end else begin
                            pc <= AW'(rdata[21:10]);
                        end
                    end else if (is_ret) begin
                        if (stk_empty) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            pc <= stk_top + AW'(1);
                        end
                    end else begin
                        pc <= pc + AW'(1);
                    end
                end
                default: begin
                    state <= ST_HALT;
                end
            endcase
        end
    end

    assign busy        = running;
    assign instr_valid = running;
    assign instr_pc    = pc;
    assign instr_word  = rdata;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R8
    ovf_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> !busy);

    // R3
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (busy && instr_pc == $past(entry_ofs[AW-1:0])));

endmodule

// File: tb/shseq_top_tb.sv
module shseq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IMG_N      = 320;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_data;
    logic        start;
    logic        busy, done, ovf_err, instr_valid;
    logic [9:0]  instr_pc;
    logic [31:0] instr_word;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] img [IMG_N];
    int          tr_pc [64];
    logic [31:0] tr_w  [64];
    int          tn = 0;
    int          dn;

    shseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .start(start), .busy(busy), .done(done),
        .ovf_err(ovf_err), .instr_valid(instr_valid), .instr_pc(instr_pc),
        .instr_word(instr_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record every presented instruction, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (instr_valid && tn < 64) begin
            tr_pc[tn] = int'(instr_pc);
            tr_w[tn]  = instr_word;
            tn++;
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected under 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] w_call(input int tgt);
        return {6'h24, 4'h0, 12'(tgt), 10'h0};
    endfunction

    localparam logic [31:0] W_RET = {6'h21, 26'h0};
    localparam logic [31:0] W_FLS = {6'h22, 26'h0};
    localparam logic [31:0] W_UNK = 32'hFC00_00AB;

    task automatic cfg_write(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        tn    = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input int max);
        dn = 0;
        for (int i = 0; i < max; i++) begin
            if (done) dn++;
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic run(input int entry, input int max);
        cfg_write(4'd0, 32'(entry));
        pulse_start();
        wait_end(max);
    endtask

    task automatic cmp_trace(input string req, input int exp [], input int n);
        chk({req, " trace length"}, 32'(tn), 32'(n));
        for (int i = 0; i < n && i < tn; i++) begin
            chk({req, " trace pc"}, 32'(tr_pc[i]), 32'(exp[i]));
        end
    endtask

    // Build the program image in the bench's own memory model.
    task automatic build_image();
        for (int i = 0; i < IMG_N; i++) img[i] = 32'h0000_1000 + 32'(i);
        img[0] = 32'h0123_4567; img[1] = w_call(5); img[2] = W_UNK;
        img[3] = W_RET;         img[5] = W_FLS;     img[6] = W_RET;
        img[20] = W_RET;
        img[190] = w_call(200); img[191] = W_RET;
        for (int k = 0; k < 8; k++) begin
            img[200 + 10*k] = w_call(210 + 10*k);
            img[201 + 10*k] = W_RET;
        end
        img[280] = W_RET;
        img[310] = W_RET;
    endtask

    // R1 R2: rewind, then write the whole image through all eight aliases.
    task automatic t_load();
        cfg_write(4'd1, 32'h0);
        for (int i = 0; i < IMG_N; i++) cfg_write(4'(8 + (i % 8)), img[i]);
    endtask

    task automatic t_reset();
        chk("R10 busy", 32'(busy), 0);
        chk("R10 done", 32'(done), 0);
        chk("R10 ovf_err", 32'(ovf_err), 0);
        chk("R10 valid", 32'(instr_valid), 0);
    endtask

    // R4 R5 R6 R7: call, flush, unknown opcode, return to word after call.
    task automatic t_basic();
        int e [] = '{0, 1, 5, 6, 2, 3};
        run(0, 100);
        cmp_trace("R5 R6 basic", e, 6);
        chk("R4 unknown opcode word", tr_w[4], W_UNK);
        chk("R4 flush word", tr_w[2], W_FLS);
        chk("R2 alias data word 0", tr_w[0], 32'h0123_4567);
        chk("R7 done once", 32'(dn), 1);
        @(negedge clk);
        chk("R7 done low after", 32'(done), 0);
    endtask

    // R3: entry offset away from zero.
    task automatic t_entry();
        int e [] = '{20};
        run(20, 100);
        cmp_trace("R3 entry", e, 1);
        chk("R3 done", 32'(dn), 1);
    endtask

    // R8 R6: full-depth nesting without overflow.
    task automatic t_nested();
        int e [17];
        for (int k = 0; k < 9; k++) e[k] = 200 + 10*k;
        for (int k = 0; k < 8; k++) e[9 + k] = 271 - 10*k;
        run(200, 200);
        cmp_trace("R6 nested eight", e, 17);
        chk("R8 no error at depth eight", 32'(ovf_err), 0);
        chk("R7 nested done", 32'(dn), 1);
    endtask

    // R9: configuration writes during a run change nothing.
    task automatic t_locked();
        int e [11];
        int b [] = '{0, 1, 5, 6, 2, 3};
        for (int k = 0; k < 11; k++) e[k] = 300 + k;
        cfg_write(4'd0, 32'd300);
        pulse_start();
        cfg_write(4'd1, 32'h0);
        cfg_write(4'd9, 32'hDEAD_BEEF);
        cfg_write(4'd0, 32'd0);
        chk("R9 still running", 32'(busy), 1);
        wait_end(100);
        cmp_trace("R9 run with writes", e, 11);
        pulse_start();
        wait_end(100);
        cmp_trace("R9 entry kept", e, 11);
        run(0, 100);
        cmp_trace("R9 word 0 kept", b, 6);
    endtask

    // R1 R2: rewind then one write replaces only word 0.
    task automatic t_rewind();
        int e0 [] = '{0};
        int e1 [] = '{1, 5, 6, 2, 3};
        cfg_write(4'd1, 32'h0);
        cfg_write(4'd15, W_RET);
        run(0, 100);
        cmp_trace("R1 rewound word 0", e0, 1);
        run(1, 100);
        cmp_trace("R2 word 1 untouched", e1, 5);
    endtask

    // R8: ninth nested call overflows and halts.
    task automatic t_overflow();
        int e [9];
        for (int k = 0; k < 9; k++) e[k] = 190 + 10*k;
        run(190, 200);
        cmp_trace("R8 overflow trace", e, 9);
        chk("R8 ovf_err set", 32'(ovf_err), 1);
        chk("R8 no done", 32'(dn), 0);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R8 start ignored", 32'(busy), 0);
        chk("R8 still sticky", 32'(ovf_err), 1);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_data = '0; start = 1'b0;
        build_image();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_basic();
        t_entry();
        t_nested();
        t_locked();
        t_rewind();
        t_overflow();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule